// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic stage of a small CPU that has no accumulator. Each operation reads two values from the register file: a left value, which is only ever a source, and a right value. The result goes back to the register named by the right-operand field of the instruction. The caller presents one instruction byte, both operand values and the current status byte, together with an issue strobe. One clock later the block returns the result, the destination index, a write-back strobe, the new status byte with its strobe, and an illegal-instruction strobe.

The upper four bits of the instruction select the operation. The lowest two bits name the destination register. Bits 3:2 name the left register for two-operand operations and pick the variant inside the unary group and the shift group. The four flags sit in the low nibble of the status byte. The high nibble passes through unchanged.

Top module: `alu8_core`

## Requirements
- R1: When status is updated, status bits 7:4 equal the incoming status bits 7:4. The flags are carry at bit 3, overflow at bit 2, zero at bit 1 and negative at bit 0.
- R2: For every legal operation, zero is set exactly when the 8-bit result is 0x00, and negative equals result bit 7. This holds for compare too, where the result is the difference.
- R3: Opcodes (instruction bits 7:4) are: MOVE=0, ADD=1, ADDC=2, SUB=3, CMP=4, AND=5, OR=6, XOR=7, UNARY=8, SHIFT=9. Every legal opcode except CMP raises write-back with destination equal to instruction bits 1:0. MOVE returns the left value.
- R4: ADD returns left+right. ADDC returns left+right+C. SUB returns left+~right+1. Carry is bit 8 of the 9-bit sum. Overflow is set when both effective addends share a sign and the result sign differs from it, where the effective addend for SUB is ~right.
- R5: CMP produces the same result and flags as SUB but raises no write-back.
- R6: MOVE, AND, OR and XOR clear carry and overflow.
- R7: In UNARY, bits 3:2 select NOT=0, NEG=1, INC=2, DEC=3. NOT and NEG clear carry. NEG is the two's-complement negation and sets overflow only for 0x80. INC sets carry on wrap from 0xFF and overflow for 0x7F. DEC sets carry on borrow from 0x00 and overflow for 0x80. NOT clears overflow.
- R8: In SHIFT, bits 3:2 select SHR=0, SHRA=1, SHLA=2, ROL=3. SHR puts the old C into bit 7. SHRA puts 0 into bit 7. Both right shifts set C from the old bit 0 and clear overflow. SHLA puts 0 into bit 0, takes C from the old bit 7, and sets overflow when bit 7 changes. ROL rotates left, takes C from the old bit 7, and clears overflow.
- R9: Opcodes 10 to 15 raise the illegal strobe and raise neither write-back nor status update.
- R10: Outputs appear one cycle after an issue. A cycle without issue is followed by all three strobes low. Reset drives all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Instruction and operands valid this cycle |
| instr_i | input | 8 | Instruction byte |
| left_i | input | 8 | Left operand value |
| right_i | input | 8 | Right operand value |
| status_i | input | 8 | Current status byte |
| result_o | output | 8 | Registered result |
| dest_o | output | 2 | Destination register index |
| wb_en_o | output | 1 | Write result to dest_o register |
| status_o | output | 8 | New status byte |
| status_en_o | output | 1 | Write status_o to status register |
| illegal_o | output | 1 | Illegal-instruction strobe |

## Verification
The only state is one stage of output registers, so any fault appears at the ports in the cycle right after the faulty issue. A wrong carry or a wrong operand inversion shows up as a wrong result or a wrong carry bit on the first boundary vector, such as 0xFF+0x01 or 0x00-0x01. A stale or misrouted strobe shows up as a write-back on a compare, or as a status update after an illegal opcode, on that same cycle. A stuck enable makes a strobe visible in the idle cycle that follows every issue.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OPC_W   = 4;
  localparam int IDX_W   = 2;
  localparam int INSTR_W = OPC_W + 2 * IDX_W;
  localparam int ST_W    = 8;
  localparam int FLG_W   = 4;
  localparam int FLG_C   = 3;
  localparam int FLG_V   = 2;
  localparam int FLG_Z   = 1;
  localparam int FLG_N   = 0;

  typedef enum logic [OPC_W-1:0] {
    OPC_MOVE  = 4'd0,
    OPC_ADD   = 4'd1,
    OPC_ADDC  = 4'd2,
    OPC_SUB   = 4'd3,
    OPC_CMP   = 4'd4,
    OPC_AND   = 4'd5,
    OPC_OR    = 4'd6,
    OPC_XOR   = 4'd7,
    OPC_UNARY = 4'd8,
    OPC_SHIFT = 4'd9
  } opc_e;

  typedef enum logic [IDX_W-1:0] {
    UN_NOT = 2'd0,
    UN_NEG = 2'd1,
    UN_INC = 2'd2,
    UN_DEC = 2'd3
  } un_e;

  typedef enum logic [IDX_W-1:0] {
    SH_SHR  = 2'd0,
    SH_SHRA = 2'd1,
    SH_SHLA = 2'd2,
    SH_ROL  = 2'd3
  } sh_e;

  typedef struct packed {
    logic c;
    logic v;
  } cv_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              invert_b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output cv_t               cv_o
);
  localparam int SUM_W = DATA_W + 1;
  localparam int MSB   = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [SUM_W-1:0]  wide;

  always_comb begin
    b_eff   = invert_b_i ? ~b_i : b_i;
    wide    = {1'b0, a_i} + {1'b0, b_eff} + SUM_W'(cin_i);
    sum_o   = wide[MSB:0];
    cv_o.c  = wide[DATA_W];
    cv_o.v  = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
  end
endmodule

// File: rtl/alu8_unary.sv
module alu8_unary
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] x_i,
  input  un_e               sel_i,
  output logic [DATA_W-1:0] res_o,
  output cv_t               cv_o
);
  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] ONE    = DATA_W'(1);
  localparam logic [DATA_W-1:0] MAXPOS = {1'b0, {MSB{1'b1}}};
  localparam logic [DATA_W-1:0] MINNEG = {1'b1, {MSB{1'b0}}};

  always_comb begin
    res_o  = ~x_i;
    cv_o   = '0;
    case (sel_i)
      UN_NOT: res_o = ~x_i;
      UN_NEG: begin
        res_o  = ~x_i + ONE;
        cv_o.v = (x_i == MINNEG);
      end
      UN_INC: begin
        {cv_o.c, res_o} = {1'b0, x_i} + (DATA_W + 1)'(1);
        cv_o.v = (x_i == MAXPOS);
      end
      UN_DEC: begin
        res_o  = x_i - ONE;
        cv_o.c = (x_i == '0);
        cv_o.v = (x_i == MINNEG);
      end
      default: res_o = ~x_i;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] x_i,
  input  sh_e               sel_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output cv_t               cv_o
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    res_o = x_i;
    cv_o  = '0;
    case (sel_i)
      SH_SHR: begin
        res_o  = {cin_i, x_i[MSB:1]};
        cv_o.c = x_i[0];
      end
      SH_SHRA: begin
        res_o  = {1'b0, x_i[MSB:1]};
        cv_o.c = x_i[0];
      end
      SH_SHLA: begin
        res_o  = {x_i[MSB-1:0], 1'b0};
        cv_o.c = x_i[MSB];
        cv_o.v = x_i[MSB] ^ x_i[MSB-1];
      end
      SH_ROL: begin
        res_o  = {x_i[MSB-1:0], x_i[MSB]};
        cv_o.c = x_i[MSB];
      end
      default: res_o = x_i;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  left_i,
  input  logic [DATA_W-1:0]  right_i,
  input  logic [ST_W-1:0]    status_i,
  output logic [DATA_W-1:0]  result_o,
  output logic [IDX_W-1:0]   dest_o,
  output logic               wb_en_o,
  output logic [ST_W-1:0]    status_o,
  output logic               status_en_o,
  output logic               illegal_o
);
  localparam int MSB = DATA_W - 1;

  opc_e              opc;
  logic [IDX_W-1:0]  sub_sel;
  logic              is_sub;
  logic              as_cin;
  logic [DATA_W-1:0] as_sum, un_res, sh_res;
  cv_t               as_cv, un_cv, sh_cv;

  logic [DATA_W-1:0] res_n;
  cv_t               cv_n;
  logic              legal_n, wb_n;
  logic [ST_W-1:0]   status_n;
  logic              load_en;

  assign opc     = opc_e'(instr_i[INSTR_W-1 -: OPC_W]);
  assign sub_sel = instr_i[2*IDX_W-1 -: IDX_W];
  assign is_sub  = (opc == OPC_SUB) || (opc == OPC_CMP);
  assign as_cin  = is_sub || ((opc == OPC_ADDC) && status_i[FLG_C]);

  alu8_addsub #(.DATA_W(DATA_W)) addsub_i (
    .a_i(left_i), .b_i(right_i), .invert_b_i(is_sub), .cin_i(as_cin),
    .sum_o(as_sum), .cv_o(as_cv)
  );

  alu8_unary #(.DATA_W(DATA_W)) unary_i (
    .x_i(right_i), .sel_i(un_e'(sub_sel)), .res_o(un_res), .cv_o(un_cv)
  );

  alu8_shift #(.DATA_W(DATA_W)) shift_i (
    .x_i(right_i), .sel_i(sh_e'(sub_sel)), .cin_i(status_i[FLG_C]),
    .res_o(sh_res), .cv_o(sh_cv)
  );

  // next-state: operation select and flag packing
  always_comb begin
    res_n   = left_i;
    cv_n    = '0;
    legal_n = 1'b1;
    wb_n    = 1'b1;
    case (opc)
      OPC_MOVE: res_n = left_i;
      OPC_ADD, OPC_ADDC, OPC_SUB: begin
        res_n = as_sum;
        cv_n  = as_cv;
      end
      OPC_CMP: begin
        res_n = as_sum;
        cv_n  = as_cv;
        wb_n  = 1'b0;
      end
      OPC_AND: res_n = left_i & right_i;
      OPC_OR:  res_n = left_i | right_i;
      OPC_XOR: res_n = left_i ^ right_i;
      OPC_UNARY: begin
        res_n = un_res;
        cv_n  = un_cv;
      end
      OPC_SHIFT: begin
        res_n = sh_res;
        cv_n  = sh_cv;
      end
      default: begin
        legal_n = 1'b0;
        wb_n    = 1'b0;
      end
    endcase
    status_n = {status_i[ST_W-1:FLG_W], cv_n.c, cv_n.v, (res_n == '0), res_n[MSB]};
  end

  assign load_en = issue_i && legal_n;

  // strobes: one-cycle pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_en_o     <= 1'b0;
      status_en_o <= 1'b0;
      illegal_o   <= 1'b0;
    end else begin
      wb_en_o     <= issue_i && wb_n;
      status_en_o <= load_en;
      illegal_o   <= issue_i && !legal_n;
    end
  end

  // data: clock-enabled on legal issue
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      dest_o   <= '0;
      status_o <= '0;
    end else if (load_en) begin
      result_o <= res_n;
      dest_o   <= instr_i[IDX_W-1:0];
      status_o <= status_n;
    end
  end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               issue_i,
  input logic [INSTR_W-1:0] instr_i,
  input logic [ST_W-1:0]    status_i,
  input logic [DATA_W-1:0]  result_o,
  input logic               wb_en_o,
  input logic [ST_W-1:0]    status_o,
  input logic               status_en_o,
  input logic               illegal_o
);
  localparam int MSB = DATA_W - 1;

  assert_high_nibble_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status_en_o |-> status_o[ST_W-1:FLG_W] == $past(status_i[ST_W-1:FLG_W]));

  assert_zero_neg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_en_o |-> (status_o[FLG_Z] == (result_o == '0)) && (status_o[FLG_N] == result_o[MSB]));

  assert_cmp_no_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |-> $past(instr_i[INSTR_W-1 -: OPC_W]) != OPC_CMP);

  assert_logic_cv_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_en_o && ($past(instr_i[INSTR_W-1 -: OPC_W]) == OPC_MOVE ||
                     $past(instr_i[INSTR_W-1 -: OPC_W]) == OPC_AND  ||
                     $past(instr_i[INSTR_W-1 -: OPC_W]) == OPC_OR   ||
                     $past(instr_i[INSTR_W-1 -: OPC_W]) == OPC_XOR))
    |-> status_o[FLG_C:FLG_V] == 2'b00);

  assert_illegal_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !wb_en_o && !status_en_o);

  assert_illegal_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(issue_i) && $past(instr_i[INSTR_W-1 -: OPC_W]) > OPC_SHIFT) |-> illegal_o);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(issue_i) |-> !wb_en_o && !status_en_o && !illegal_o);
endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .instr_i(instr_i),
  .status_i(status_i), .result_o(result_o), .wb_en_o(wb_en_o),
  .status_o(status_o), .status_en_o(status_en_o), .illegal_o(illegal_o)
);

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       issue_i;
  logic [7:0] instr_i, left_i, right_i, status_i;
  logic [7:0] result_o, status_o;
  logic [1:0] dest_o;
  logic       wb_en_o, status_en_o, illegal_o;

  int total = 0;
  int bad   = 0;

  typedef struct packed {
    logic [7:0] res;
    logic [7:0] stat;
    logic       wb;
    logic       err;
  } exp_t;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core dut_i (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .instr_i(instr_i),
    .left_i(left_i), .right_i(right_i), .status_i(status_i),
    .result_o(result_o), .dest_o(dest_o), .wb_en_o(wb_en_o),
    .status_o(status_o), .status_en_o(status_en_o), .illegal_o(illegal_o)
  );

  function automatic exp_t ref_model(input logic [7:0] ins, l, r, st);
    exp_t       e;
    logic [3:0] op;
    logic [1:0] sub;
    logic [7:0] res, b;
    logic [8:0] w;
    logic       c, v, cin;
    op = ins[7:4]; sub = ins[3:2];
    e.err = 1'b0; e.wb = 1'b1; c = 1'b0; v = 1'b0; res = l;
    b = r; cin = 1'b0; w = '0;
    case (op)
      4'd0: res = l;
      4'd1, 4'd2, 4'd3, 4'd4: begin
        b   = (op >= 4'd3) ? ~r : r;
        cin = (op >= 4'd3) ? 1'b1 : ((op == 4'd2) ? st[3] : 1'b0);
        w   = {1'b0, l} + {1'b0, b} + {8'd0, cin};
        res = w[7:0]; c = w[8];
        v   = (l[7] == b[7]) && (res[7] != l[7]);
        if (op == 4'd4) e.wb = 1'b0;
      end
      4'd5: res = l & r;
      4'd6: res = l | r;
      4'd7: res = l ^ r;
      4'd8: case (sub)
        2'd0: res = ~r;
        2'd1: begin res = 8'd0 - r; v = (r == 8'h80); end
        2'd2: begin res = r + 8'd1; c = (r == 8'hFF); v = (r == 8'h7F); end
        default: begin res = r - 8'd1; c = (r == 8'h00); v = (r == 8'h80); end
      endcase
      4'd9: case (sub)
        2'd0: begin res = {st[3], r[7:1]}; c = r[0]; end
        2'd1: begin res = {1'b0, r[7:1]}; c = r[0]; end
        2'd2: begin res = {r[6:0], 1'b0}; c = r[7]; v = r[7] ^ r[6]; end
        default: begin res = {r[6:0], r[7]}; c = r[7]; end
      endcase
      default: begin e.err = 1'b1; e.wb = 1'b0; end
    endcase
    e.res  = res;
    e.stat = {st[7:4], c, v, (res == 8'd0), res[7]};
    return e;
  endfunction

  task automatic run_op(input logic [7:0] ins, l, r, st, input string tag);
    exp_t e;
    logic ok;
    e = ref_model(ins, l, r, st);
    @(negedge clk);
    issue_i = 1'b1; instr_i = ins; left_i = l; right_i = r; status_i = st;
    @(negedge clk);
    issue_i = 1'b0;
    ok = (illegal_o == e.err) && (wb_en_o == e.wb) && (status_en_o == !e.err);
    if (!e.err) ok = ok && (result_o == e.res) && (status_o == e.stat);
    if (e.wb)   ok = ok && (dest_o == ins[1:0]);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s ins=%h l=%h r=%h st=%h: actual ill=%b wb=%b sen=%b dst=%0d res=%h st=%h expected ill=%b wb=%b res=%h st=%h",
               tag, ins, l, r, st, illegal_o, wb_en_o, status_en_o, dest_o, result_o, status_o,
               e.err, e.wb, e.res, e.stat);
    end
  endtask

  task automatic check_quiet(input string tag);
    @(negedge clk);
    total++;
    if (wb_en_o || status_en_o || illegal_o) begin
      bad++;
      $display("FAIL %s: actual strobes wb=%b sen=%b ill=%b expected 000", tag, wb_en_o, status_en_o, illegal_o);
    end
  endtask

  task automatic t_reset();
    total++;
    if (result_o !== 8'd0 || status_o !== 8'd0 || dest_o !== 2'd0 || wb_en_o !== 1'b0 ||
        status_en_o !== 1'b0 || illegal_o !== 1'b0) begin
      bad++;
      $display("FAIL R10 reset: actual res=%h st=%h dst=%0d wb=%b sen=%b ill=%b expected all zero",
               result_o, status_o, dest_o, wb_en_o, status_en_o, illegal_o);
    end
  endtask

  task automatic t_move_logic();
    run_op(8'h0_6, 8'h00, 8'h55, 8'hAC, "R3 R6 R2 move zero");
    run_op(8'h0_1, 8'h9A, 8'h00, 8'h5C, "R3 R1 move negative");
    run_op(8'h5_3, 8'hF0, 8'h0F, 8'hFC, "R6 R2 and zero");
    run_op(8'h6_2, 8'h80, 8'h01, 8'h3C, "R6 or");
    run_op(8'h7_0, 8'hA5, 8'hA5, 8'hCC, "R6 R2 xor equal");
  endtask

  task automatic t_add();
    run_op(8'h1_1, 8'h7F, 8'h01, 8'h00, "R4 add signed overflow");
    run_op(8'h1_2, 8'hFF, 8'h01, 8'h90, "R4 R2 add carry zero");
    run_op(8'h1_3, 8'h80, 8'h80, 8'h00, "R4 add neg overflow");
    run_op(8'h2_0, 8'h10, 8'h20, 8'h08, "R4 addc carry in 1");
    run_op(8'h2_0, 8'h10, 8'h20, 8'h00, "R4 addc carry in 0");
    run_op(8'h2_1, 8'hFF, 8'h00, 8'h08, "R4 addc ripple");
  endtask

  task automatic t_sub_cmp();
    run_op(8'h3_1, 8'h00, 8'h01, 8'h00, "R4 sub borrow");
    run_op(8'h3_2, 8'h80, 8'h01, 8'h08, "R4 sub overflow");
    run_op(8'h3_3, 8'h05, 8'h05, 8'h00, "R4 sub equal");
    run_op(8'h4_1, 8'h33, 8'h33, 8'h70, "R5 cmp equal no write");
    run_op(8'h4_2, 8'h10, 8'h20, 8'h00, "R5 cmp less");
  endtask

  task automatic t_unary();
    run_op(8'h8_0, 8'h00, 8'h3C, 8'h0C, "R7 not");
    run_op(8'h8_4, 8'h00, 8'h80, 8'h08, "R7 neg 0x80");
    run_op(8'h8_5, 8'h00, 8'h01, 8'h08, "R7 neg one");
    run_op(8'h8_6, 8'h00, 8'h00, 8'h08, "R7 neg zero");
    run_op(8'h8_8, 8'h00, 8'h7F, 8'h00, "R7 inc 0x7F");
    run_op(8'h8_9, 8'h00, 8'hFF, 8'h00, "R7 inc wrap");
    run_op(8'h8_C, 8'h00, 8'h80, 8'h00, "R7 dec 0x80");
    run_op(8'h8_D, 8'h00, 8'h00, 8'h00, "R7 dec borrow");
  endtask

  task automatic t_shift();
    for (int ci = 0; ci < 2; ci++) begin
      logic [7:0] st;
      st = ci[0] ? 8'h68 : 8'h60;
      run_op(8'h9_0, 8'h00, 8'h81, st, "R8 shr");
      run_op(8'h9_5, 8'h00, 8'h81, st, "R8 shra");
      run_op(8'h9_A, 8'h00, 8'h40, st, "R8 shla bit7 change");
      run_op(8'h9_B, 8'h00, 8'hC1, st, "R8 shla carry");
      run_op(8'h9_E, 8'h00, 8'h81, st, "R8 rol");
    end
  endtask

  task automatic t_illegal();
    for (int op = 10; op < 16; op++) begin
      run_op({op[3:0], 4'h5}, 8'h12, 8'h34, 8'hFF, "R9 illegal opcode");
    end
    check_quiet("R10 idle after illegal");
  endtask

  task automatic t_random();
    for (int n = 0; n < 400; n++) begin
      logic [7:0] ins;
      ins = {4'($urandom_range(0, 9)), 4'($urandom)};
      run_op(ins, 8'($urandom), 8'($urandom), 8'($urandom), "R3 R4 R7 R8 random");
    end
    check_quiet("R10 idle after random");
  endtask

  initial begin
    rst_n = 1'b0; issue_i = 1'b0; instr_i = '0; left_i = '0; right_i = '0; status_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("R10 idle after reset");
    t_move_logic();
    t_add();
    t_sub_cmp();
    t_unary();
    t_shift();
    t_illegal();
    t_random();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    total++;
    bad++;
    $display("FAIL watchdog: actual run still busy, expected finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule